// File: doc/BRIEF.md
# Storage-to-Storage Byte Move Engine

This engine carries out a single six-byte memory-to-memory move instruction. A 48-bit instruction word is presented with a one-cycle `start` pulse. The engine checks the operation code and decodes a length byte and two operand addresses. Each operand address is a base register selector plus a 12-bit displacement. It reads the two base registers one after the other through a single read port into a 16-entry register file, and forms 24-bit effective addresses. It then copies the field one byte at a time over a single-port, byte-wide synchronous memory.

The length byte holds the byte count minus one, so a single instruction moves between 1 and 256 bytes. Only the destination operand supplies the count. Each byte is read from the source and then written to the destination, in ascending address order. When the fields overlap, bytes already written can therefore be read again further along the move. `busy` is high from the cycle after an accepted start until the last write. `done` then pulses for one cycle. Any other opcode raises `illegal_op` for one cycle and makes no memory access.

Top module: `ss_byte_mover`

## Requirements
- R1: After reset, `busy`, `done`, `illegal_op`, `mem_rd_en` and `mem_wr_en` are all low.
- R2: Only opcode 0xD2 in `instr[47:40]` starts a move. With any other opcode, `start` raises `illegal_op` for exactly one cycle, in the cycle after `start`. `busy` stays low and no memory read or write occurs.
- R3: The length byte `instr[39:32]` holds N-1, and the move performs exactly N reads and N writes, so 0x00 moves 1 byte and 0xFF moves 256 bytes.
- R4: The destination operand is `instr[31:16]` and the source operand is `instr[15:0]`. In each operand, the upper 4 bits select a base register and the lower 12 bits are an unsigned displacement. The effective address is the low 24 bits of that register plus the zero-extended displacement, modulo 2^24.
- R5: A base selector of 0 contributes zero to the effective address, whatever register 0 holds.
- R6: Byte i (from 0) is read from source address + i and then written to destination address + i, for ascending i. Overlapping fields therefore propagate bytes already written.
- R7: `busy` is high from the cycle after an accepted `start` until the cycle of the last write. `done` is a one-cycle pulse in the cycle after the last write, with `busy` low.
- R8: `start` is ignored while a move is in progress. The second instruction causes no extra access and no `illegal_op`.
- R9: Memory read data arrives one cycle after `mem_rd_en`. Each write directly follows its read and stores the byte that read returned.
- R10: `mem_rd_en` and `mem_wr_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to execute `instr` |
| instr | input | 48 | Instruction word: opcode, length, destination and source operands |
| busy | output | 1 | A move is in progress |
| done | output | 1 | One-cycle pulse after the final write |
| illegal_op | output | 1 | One-cycle pulse for a rejected opcode |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | 32 | Register file read data, combinational from `rf_raddr` |
| mem_addr | output | 24 | Memory byte address |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after `mem_rd_en` |

## Verification
The assertions assume the following about the block's inputs:
- `rf_rdata` answers `rf_raddr` within the same cycle.
- The memory returns read data exactly one cycle after each read strobe.
- `start` is a single-cycle pulse.

The bench holds to these assumptions by modelling both the register file and the memory itself. It drives `start` on falling edges for one cycle at a time. The memory model is 4096 bytes indexed by the low 12 bits of the address, which wraps consistently with the 24-bit address. Wrap and overlap cases can therefore be compared byte for byte against a reference copy made in the bench.

// File: rtl/ssmv_pkg.sv
`timescale 1ns/1ps
package ssmv_pkg;
    // Instruction layout (fixed by the format)
    localparam int INSTR_W = 48;
    localparam int OPC_W   = 8;
    localparam int LEN_W   = 8;
    localparam int RIDX_W  = 4;
    localparam int DISP_W  = 12;
    localparam int OPND_W  = RIDX_W + DISP_W;

    // One base/displacement operand
    typedef struct packed {
        logic [RIDX_W-1:0] base;
        logic [DISP_W-1:0] disp;
    } opnd_t;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_EA_DST = 3'd1,
        ST_EA_SRC = 3'd2,
        ST_READ   = 3'd3,
        ST_WRITE  = 3'd4,
        ST_FINISH = 3'd5
    } mv_state_t;
endpackage

// File: rtl/ssmv_decode.sv
`timescale 1ns/1ps
module ssmv_decode
    import ssmv_pkg::*;
#(
    parameter logic [OPC_W-1:0] OPC_MOVE = 8'hD2
) (
    input  logic [INSTR_W-1:0] instr,
    output logic               is_move,
    output logic [LEN_W-1:0]   len_m1,
    output opnd_t              dst,
    output opnd_t              src
);
    localparam int OPC_LSB = INSTR_W - OPC_W;
    localparam int LEN_LSB = OPC_LSB - LEN_W;
    localparam int DST_LSB = LEN_LSB - OPND_W;

    logic [OPC_W-1:0] opcode;

    always_comb begin
        opcode  = instr[OPC_LSB +: OPC_W];
        is_move = (opcode == OPC_MOVE);
        len_m1  = instr[LEN_LSB +: LEN_W];
        dst     = opnd_t'(instr[DST_LSB +: OPND_W]);
        src     = opnd_t'(instr[0 +: OPND_W]);
    end
endmodule

// File: rtl/ssmv_ea_gen.sv
`timescale 1ns/1ps
module ssmv_ea_gen
    import ssmv_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int REG_W  = 32
) (
    input  opnd_t              opnd,
    input  logic [REG_W-1:0]   reg_val,
    output logic [ADDR_W-1:0]  ea
);
    logic [ADDR_W-1:0] base_val;

    // Fit the register value to the address width
    generate
        if (REG_W > ADDR_W) begin : g_trunc
            logic unused_hi;
            assign unused_hi = ^reg_val[REG_W-1:ADDR_W];
            assign base_val  = reg_val[ADDR_W-1:0];
        end else if (REG_W == ADDR_W) begin : g_same
            assign base_val = reg_val;
        end else begin : g_ext
            assign base_val = {{(ADDR_W-REG_W){1'b0}}, reg_val};
        end
    endgenerate

    always_comb begin
        if (opnd.base == '0)
            ea = ADDR_W'(opnd.disp);
        else
            ea = base_val + ADDR_W'(opnd.disp);
    end
endmodule

// File: rtl/ss_byte_mover.sv
`timescale 1ns/1ps
module ss_byte_mover
    import ssmv_pkg::*;
#(
    parameter int                ADDR_W   = 24,
    parameter int                REG_W    = 32,
    parameter int                DATA_W   = 8,
    parameter logic [OPC_W-1:0]  OPC_MOVE = 8'hD2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [INSTR_W-1:0] instr,
    output logic               busy,
    output logic               done,
    output logic               illegal_op,
    output logic [RIDX_W-1:0]  rf_raddr,
    input  logic [REG_W-1:0]   rf_rdata,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_rd_en,
    output logic               mem_wr_en,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata
);
    typedef struct packed {
        mv_state_t         state;
        opnd_t             dst;
        opnd_t             src;
        logic [LEN_W-1:0]  remain;
        logic [ADDR_W-1:0] dst_ea;
        logic [ADDR_W-1:0] src_ea;
        logic              illegal;
    } mv_reg_t;

    mv_reg_t r_q, r_d;

    logic             dec_is_move;
    logic [LEN_W-1:0] dec_len;
    opnd_t            dec_dst, dec_src;
    opnd_t            ea_opnd;
    logic [ADDR_W-1:0] ea_val;

    ssmv_decode #(.OPC_MOVE(OPC_MOVE)) u_decode (
        .instr   (instr),
        .is_move (dec_is_move),
        .len_m1  (dec_len),
        .dst     (dec_dst),
        .src     (dec_src)
    );

    // One shared address adder; the register port is time-shared
    assign ea_opnd  = (r_q.state == ST_EA_DST) ? r_q.dst : r_q.src;
    assign rf_raddr = ea_opnd.base;

    ssmv_ea_gen #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_ea (
        .opnd    (ea_opnd),
        .reg_val (rf_rdata),
        .ea      (ea_val)
    );

    always_comb begin
        r_d         = r_q;
        r_d.illegal = 1'b0;
        mem_addr    = r_q.src_ea;
        mem_rd_en   = 1'b0;
        mem_wr_en   = 1'b0;
        mem_wdata   = mem_rdata;
        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (dec_is_move) begin
                        r_d.dst    = dec_dst;
                        r_d.src    = dec_src;
                        r_d.remain = dec_len;
                        r_d.state  = ST_EA_DST;
                    end else begin
                        r_d.illegal = 1'b1;
                    end
                end
            end
            ST_EA_DST: begin
                r_d.dst_ea = ea_val;
                r_d.state  = ST_EA_SRC;
            end
            ST_EA_SRC: begin
                r_d.src_ea = ea_val;
                r_d.state  = ST_READ;
            end
            ST_READ: begin
                mem_rd_en = 1'b1;
                mem_addr  = r_q.src_ea;
                r_d.state = ST_WRITE;
            end
            ST_WRITE: begin
                mem_wr_en  = 1'b1;
                mem_addr   = r_q.dst_ea;
                r_d.dst_ea = r_q.dst_ea + 1'b1;
                r_d.src_ea = r_q.src_ea + 1'b1;
                if (r_q.remain == '0) begin
                    r_d.state = ST_FINISH;
                end else begin
                    r_d.remain = r_q.remain - 1'b1;
                    r_d.state  = ST_READ;
                end
            end
            ST_FINISH: r_d.state = ST_IDLE;
            default:   r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy       = (r_q.state == ST_EA_DST) || (r_q.state == ST_EA_SRC) ||
                        (r_q.state == ST_READ)   || (r_q.state == ST_WRITE);
    assign done       = (r_q.state == ST_FINISH);
    assign illegal_op = r_q.illegal;

    // Assertions
    AST_SINGLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en)); // R10
    AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(mem_rd_en)); // R9
    AST_ASCENDING_DST: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && $past(mem_wr_en, 2)) |-> mem_addr == ADDR_W'($past(mem_addr, 2) + 1'b1)); // R6
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> (!busy && !mem_rd_en && !mem_wr_en)); // R2
    AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |=> !illegal_op); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mem_wr_en) && !busy)); // R7
    AST_NO_ILLEGAL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !illegal_op); // R8
endmodule

// File: tb/ss_byte_mover_tb_top.sv
`timescale 1ns/1ps
module ss_byte_mover_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [47:0] instr = '0;
    logic        busy, done, illegal_op;
    logic [3:0]  rf_raddr;
    logic [31:0] rf_rdata;
    logic [23:0] mem_addr;
    logic        mem_rd_en, mem_wr_en;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    logic [31:0] rf [16];
    logic [7:0]  mem [4096];
    logic [7:0]  ref_m [4096];

    logic        fill = 1'b0;
    logic [7:0]  fill_seed = '0;
    logic        mon_clr = 1'b0;
    int          wr_cnt = 0, rd_cnt = 0, done_cnt = 0;
    logic [23:0] first_wr = '0;

    int tests = 0, fails = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    assign rf_rdata = rf[rf_raddr];

    ss_byte_mover dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .busy(busy), .done(done), .illegal_op(illegal_op),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory model: one-cycle read latency, bulk fill on request
    always @(posedge clk) begin
        if (fill) begin
            for (int k = 0; k < 4096; k++) mem[k] <= 8'(k * 13 + int'(fill_seed));
        end else begin
            if (mem_rd_en) mem_rdata <= mem[mem_addr[11:0]];
            if (mem_wr_en) mem[mem_addr[11:0]] <= mem_wdata;
        end
    end

    // Access monitor
    always @(posedge clk) begin
        if (mon_clr) begin
            wr_cnt <= 0; rd_cnt <= 0; done_cnt <= 0;
        end else begin
            if (mem_wr_en) begin
                if (wr_cnt == 0) first_wr <= mem_addr;
                wr_cnt <= wr_cnt + 1;
            end
            if (mem_rd_en) rd_cnt <= rd_cnt + 1;
            if (done) done_cnt <= done_cnt + 1;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            $display("FAIL watchdog: act=%0d cycles exp<=190000", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests + 1, fails + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_ea(input logic [3:0] b, input logic [11:0] d);
        return (b == 4'd0 ? 24'h0 : rf[b][23:0]) + {12'h0, d};
    endfunction

    function automatic logic [47:0] mk(input logic [7:0] opc, input logic [7:0] len,
                                       input logic [3:0] db, input logic [11:0] dd,
                                       input logic [3:0] sb, input logic [11:0] sd);
        return {opc, len, db, dd, sb, sd};
    endfunction

    task automatic do_fill(input logic [7:0] seed);
        @(negedge clk);
        fill = 1'b1; fill_seed = seed;
        @(negedge clk);
        fill = 1'b0;
        for (int k = 0; k < 4096; k++) ref_m[k] = 8'(k * 13 + int'(seed));
    endtask

    task automatic ref_copy(input logic [47:0] ins);
        logic [23:0] d, s;
        d = exp_ea(ins[31:28], ins[27:16]);
        s = exp_ea(ins[15:12], ins[11:0]);
        for (int i = 0; i <= int'(ins[39:32]); i++)
            ref_m[12'(d[11:0] + 12'(i))] = ref_m[12'(s[11:0] + 12'(i))];
    endtask

    task automatic cmp_mem(input string req);
        int bad = 0; int first = -1;
        for (int k = 0; k < 4096; k++)
            if (mem[k] !== ref_m[k]) begin
                bad++;
                if (first < 0) first = k;
            end
        chk(bad == 0, req, "memory mismatches (first index)", bad, 0);
        if (bad != 0) $display("  first bad index %0h", first);
    endtask

    task automatic wait_done(output bit seen);
        int n = 0;
        seen = 0;
        while (!done && n < 3000) begin @(negedge clk); n++; end
        seen = done;
    endtask

    // Full move with all checks; interrupt_at>0 pulses a second start mid-move
    task automatic run_move(input logic [47:0] ins, input string tag, input int interrupt_at);
        bit seen;
        int n;
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0; start = 1'b1; instr = ins;
        @(negedge clk); start = 1'b0;
        chk(busy === 1'b1, "R7", {tag, " busy after start"}, busy, 1);
        if (interrupt_at > 0) begin
            for (int i = 0; i < interrupt_at; i++) @(negedge clk);
            start = 1'b1;
            instr = mk(8'hD2, 8'h05, 4'd0, 12'hF00, 4'd0, 12'h000);
            @(negedge clk); start = 1'b0;
            chk(illegal_op === 1'b0, "R8", {tag, " no illegal on ignored start"}, illegal_op, 0);
        end
        wait_done(seen);
        chk(seen, "R7", {tag, " done seen"}, seen, 1);
        chk(busy === 1'b0, "R7", {tag, " busy low at done"}, busy, 0);
        @(negedge clk);
        chk(done === 1'b0, "R7", {tag, " done one cycle"}, done, 0);
        for (n = 0; n < 6; n++) @(negedge clk);
        chk(done_cnt == 1, "R7", {tag, " done count"}, done_cnt, 1);
        chk(wr_cnt == int'(ins[39:32]) + 1, "R3", {tag, " write count"}, wr_cnt, int'(ins[39:32]) + 1);
        chk(rd_cnt == int'(ins[39:32]) + 1, "R9", {tag, " read count"}, rd_cnt, int'(ins[39:32]) + 1);
        chk(first_wr == exp_ea(ins[31:28], ins[27:16]), "R4", {tag, " first dst addr"},
            first_wr, exp_ea(ins[31:28], ins[27:16]));
        ref_copy(ins);
        cmp_mem("R6");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) rf[i] = 32'hAB000000 | 32'(i * 64);
        rf[0] = 32'h00000F00;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(!busy && !done && !illegal_op && !mem_rd_en && !mem_wr_en, "R1",
            "outputs in reset", {busy, done, illegal_op, mem_rd_en, mem_wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !illegal_op && !mem_rd_en && !mem_wr_en, "R1",
            "outputs after reset", {busy, done, illegal_op, mem_rd_en, mem_wr_en}, 0);

        // R3/R4/R6: sweep every length with rotating base registers
        for (int l = 0; l < 256; l++) begin
            logic [3:0] db, sb;
            db = 4'(1 + (l % 15));
            sb = 4'(1 + ((l + 7) % 15));
            if ((l % 32) == 0) do_fill(8'(l));
            run_move(mk(8'hD2, 8'(l), db, 12'h800 + 12'(l), sb, 12'h010), "R3 sweep", 0);
        end

        // R6 overlap: destination one above source propagates the first byte
        do_fill(8'h5A);
        run_move(mk(8'hD2, 8'd15, 4'd0, 12'h101, 4'd0, 12'h100), "R6 overlap up", 0);
        chk(mem[12'h110] === mem[12'h100], "R6", "propagated byte", mem[12'h110], mem[12'h100]);
        // R6 overlap: destination below source
        run_move(mk(8'hD2, 8'd31, 4'd0, 12'h200, 4'd0, 12'h204), "R6 overlap down", 0);

        // R5 base selector 0 ignores register 0 contents
        run_move(mk(8'hD2, 8'd7, 4'd0, 12'h300, 4'd0, 12'h020), "R5 base zero", 0);
        chk(first_wr == 24'h000300, "R5", "base0 dst addr", first_wr, 24'h000300);

        // R4 wrap modulo 2^24
        rf[14] = 32'h12FFFFF8;
        run_move(mk(8'hD2, 8'd3, 4'd14, 12'h010, 4'd2, 12'h000), "R4 wrap", 0);
        chk(first_wr == 24'h000008, "R4", "wrapped dst addr", first_wr, 24'h000008);

        // R3 full 256-byte move
        do_fill(8'hC3);
        run_move(mk(8'hD2, 8'hFF, 4'd3, 12'h900, 4'd5, 12'h000), "R3 max", 0);

        // R8 start ignored while busy
        run_move(mk(8'hD2, 8'd40, 4'd1, 12'hA00, 4'd2, 12'h000), "R8 ignore", 10);

        // R2 every other opcode is rejected
        for (int op = 0; op < 256; op++) begin
            if (op == 8'hD2) continue;
            @(negedge clk); mon_clr = 1'b1;
            @(negedge clk); mon_clr = 1'b0; start = 1'b1;
            instr = mk(8'(op), 8'h10, 4'd1, 12'h000, 4'd2, 12'h000);
            @(negedge clk); start = 1'b0;
            chk(illegal_op === 1'b1 && busy === 1'b0, "R2", "illegal flag",
                {illegal_op, busy}, 2'b10);
            @(negedge clk);
            chk(illegal_op === 1'b0, "R2", "illegal one cycle", illegal_op, 0);
            repeat (3) @(negedge clk);
            chk(rd_cnt == 0 && wr_cnt == 0 && busy === 1'b0, "R2", "no access",
                rd_cnt + wr_cnt, 0);
        end
        cmp_mem("R2");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule